// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between the interrupt sources of one processor and its core. It keeps three bitmaps, one bit per vector: requests waiting for service, vectors the core is servicing, and whether each waiting or serviced vector was level-triggered. A request arrives with a vector number and a trigger mode. The unit always presents the highest waiting vector whose priority class beats the current processor priority.

The processor priority combines a software-written task priority with the class of the highest vector in service. When the core acknowledges, the presented vector moves from waiting to in service. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, a one-cycle broadcast strobe carries its number out, so that the source can re-arm.

Top module: `irq_accept_unit`

## Requirements
- R1: Reset clears all three bitmaps and the task priority. After reset `irq_avail`, `eoi_bcast` and `req_err` are low.
- R2: Of the waiting vectors, `irq_vec` presents the one with the highest number, including between vectors of the same priority class (class = vector bits [7:4]).
- R3: The processor priority equals the task priority when task priority[7:4] >= the class of the highest in-service vector. Otherwise it equals that in-service vector with bits [3:0] cleared. An empty in-service set counts as vector 0. A waiting vector is presented only when {vector[7:4],4'h0} is strictly greater than the processor priority.
- R4: An acknowledge in a cycle with `irq_avail` high moves the presented vector from waiting to in service, and the priority is recomputed for the next cycle. An acknowledge while `irq_avail` is low changes nothing.
- R5: An end-of-interrupt retires the highest in-service vector. An end-of-interrupt with nothing in service has no effect.
- R6: When the retired vector was level-triggered, `eoi_bcast` is high for exactly the one cycle after the end-of-interrupt, with `eoi_bcast_vec` holding the vector. When the retired vector was edge-triggered, no broadcast occurs.
- R7: A request marks the vector waiting and records its trigger mode (`req_level`=1 for level, 0 for edge). A level request for a vector that is already waiting is dropped and leaves the recorded mode unchanged.
- R8: Requests are ignored unless both `hw_en` and `sw_en` are high.
- R9: An enabled request for a vector below 16 is dropped, and `req_err` is high in the following cycle. Vectors 16 and up raise no error.
- R10: A task-priority write takes effect on the presented interrupt in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware enable for request acceptance |
| sw_en | input | 1 | Software enable for request acceptance |
| req_valid | input | 1 | Incoming interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| ack | input | 1 | Core acknowledges the presented vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_avail | output | 1 | A deliverable vector is presented |
| irq_vec | output | 8 | Presented vector (0 when none) |
| eoi_bcast | output | 1 | Level-triggered vector retired |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |
| req_err | output | 1 | Illegal vector was requested in the previous cycle |

## Verification
The hardest states to reach are nested in-service vectors, where the in-service class rather than the task priority gates delivery, and a level request that hits an already waiting edge vector. The stimulus builds a nest on purpose: it acknowledges a lower-class vector, then raises a higher-class level request and acknowledges it as well. It then retires the two vectors one at a time and watches the priority unwind. The level-on-edge collision is detected by the absence of a broadcast when that vector is later retired.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int unsigned NUM_VEC_DFLT = 256;
    localparam int unsigned WORD_W_DFLT  = 32;
    localparam int unsigned VEC_W        = 8;
    localparam int unsigned CLS_LSB      = 4;
    localparam int unsigned RSVD_VEC     = 16;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic found;
        vec_t vec;
    } hit_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        logic level;
    } req_t;

    function automatic vec_t class_of(input vec_t v);
        return v & ~vec_t'((1 << CLS_LSB) - 1);
    endfunction

endpackage

// File: rtl/iau_msb_scan.sv
module iau_msb_scan
    import irq_accept_pkg::*;
#(
    parameter int unsigned NUM_VEC = NUM_VEC_DFLT,
    parameter int unsigned WORD_W  = WORD_W_DFLT
) (
    input  logic [NUM_VEC-1:0] bits,
    output hit_t               hit
);
    localparam int unsigned NWORD = NUM_VEC / WORD_W;
    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic [NWORD-1:0] word_any;
    logic [IDX_W-1:0] word_idx [NWORD];

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic [WORD_W-1:0] slice;
        assign slice       = bits[w*WORD_W +: WORD_W];
        assign word_any[w] = |slice;
        always_comb begin
            word_idx[w] = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (slice[b]) word_idx[w] = IDX_W'(b);
            end
        end
    end

    // Later (higher) words overwrite earlier ones: the top non-empty word wins.
    always_comb begin
        hit = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (word_any[w]) begin
                hit.found = 1'b1;
                hit.vec   = VEC_W'(w * WORD_W + int'(word_idx[w]));
            end
        end
    end

endmodule

// File: rtl/iau_prio.sv
module iau_prio
    import irq_accept_pkg::*;
(
    input  vec_t tpr,
    input  hit_t isr_hit,
    input  hit_t pend_hit,
    output vec_t ppr,
    output logic offer_valid,
    output vec_t offer_vec
);
    vec_t isr_v;

    always_comb begin
        isr_v = isr_hit.found ? isr_hit.vec : '0;
        if (tpr[VEC_W-1:CLS_LSB] >= isr_v[VEC_W-1:CLS_LSB])
            ppr = tpr;
        else
            ppr = class_of(isr_v);
        offer_valid = pend_hit.found && (class_of(pend_hit.vec) > ppr);
        offer_vec   = offer_valid ? pend_hit.vec : '0;
    end

endmodule

// File: rtl/iau_state.sv
module iau_state
    import irq_accept_pkg::*;
#(
    parameter int unsigned NUM_VEC = NUM_VEC_DFLT
) (
    input  logic               clk,
    input  logic               rst,
    input  req_t               req,
    input  logic               ack_fire,
    input  vec_t               ack_vec,
    input  logic               eoi_fire,
    input  vec_t               eoi_vec,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] isr_q,
    output logic [NUM_VEC-1:0] trig_q,
    output logic               bcast_fire
);
    logic [NUM_VEC-1:0] pend_n, isr_n, trig_n;

    always_comb begin
        pend_n     = pend_q;
        isr_n      = isr_q;
        trig_n     = trig_q;
        bcast_fire = 1'b0;
        if (ack_fire) begin
            pend_n[ack_vec] = 1'b0;
            isr_n[ack_vec]  = 1'b1;
        end
        if (eoi_fire) begin
            isr_n[eoi_vec] = 1'b0;
            if (trig_q[eoi_vec]) begin
                trig_n[eoi_vec] = 1'b0;
                bcast_fire      = 1'b1;
            end
        end
        if (req.valid && !(req.level && pend_q[req.vec])) begin
            pend_n[req.vec] = 1'b1;
            trig_n[req.vec] = req.level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            isr_q  <= '0;
            trig_q <= '0;
        end else begin
            pend_q <= pend_n;
            isr_q  <= isr_n;
            trig_q <= trig_n;
        end
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int unsigned NUM_VEC = NUM_VEC_DFLT,
    parameter int unsigned WORD_W  = WORD_W_DFLT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_en,
    input  logic       sw_en,
    input  logic       req_valid,
    input  logic [7:0] req_vec,
    input  logic       req_level,
    input  logic       tpr_we,
    input  logic [7:0] tpr_wdata,
    input  logic       ack,
    input  logic       eoi,
    output logic       irq_avail,
    output logic [7:0] irq_vec,
    output logic       eoi_bcast,
    output logic [7:0] eoi_bcast_vec,
    output logic       req_err
);
    logic [NUM_VEC-1:0] pend_q, isr_q, trig_q;
    hit_t pend_hit, isr_hit;
    vec_t tpr_q, ppr, offer_vec;
    logic offer_valid, bcast_fire, accept_en, legal;
    req_t acc_req;

    assign accept_en     = hw_en & sw_en;
    assign legal         = req_vec >= vec_t'(RSVD_VEC);
    assign acc_req.valid = req_valid & accept_en & legal;
    assign acc_req.vec   = req_vec;
    assign acc_req.level = req_level;

    iau_msb_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_pend (
        .bits(pend_q), .hit(pend_hit)
    );
    iau_msb_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_isr (
        .bits(isr_q), .hit(isr_hit)
    );

    iau_prio u_prio (
        .tpr(tpr_q), .isr_hit(isr_hit), .pend_hit(pend_hit),
        .ppr(ppr), .offer_valid(offer_valid), .offer_vec(offer_vec)
    );

    iau_state #(.NUM_VEC(NUM_VEC)) u_state (
        .clk(clk), .rst(rst), .req(acc_req),
        .ack_fire(ack & offer_valid), .ack_vec(offer_vec),
        .eoi_fire(eoi & isr_hit.found), .eoi_vec(isr_hit.vec),
        .pend_q(pend_q), .isr_q(isr_q), .trig_q(trig_q),
        .bcast_fire(bcast_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q         <= '0;
            eoi_bcast     <= 1'b0;
            eoi_bcast_vec <= '0;
            req_err       <= 1'b0;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            eoi_bcast     <= bcast_fire;
            eoi_bcast_vec <= bcast_fire ? isr_hit.vec : '0;
            req_err       <= req_valid & accept_en & ~legal;
        end
    end

    assign irq_avail = offer_valid;
    assign irq_vec   = offer_vec;

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
    parameter int unsigned NUM_VEC = 256
) (
    input logic               clk,
    input logic               rst,
    input logic               hw_en,
    input logic               sw_en,
    input logic               req_valid,
    input logic [7:0]         req_vec,
    input logic               ack,
    input logic               eoi,
    input logic               irq_avail,
    input logic [7:0]         irq_vec,
    input logic               eoi_bcast,
    input logic               req_err,
    input logic [NUM_VEC-1:0] pend_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [7:0]         ppr
);
    // R1: state empty right after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0 && isr_q == '0 && !irq_avail));

    // R3: presented vector class beats processor priority
    a_r3_offer_above_ppr: assert property (@(posedge clk) disable iff (rst)
        irq_avail |-> ({irq_vec[7:4], 4'h0} > ppr));

    // R4: acknowledged vector is in service next cycle
    a_r4_ack_to_isr: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_avail) |=> isr_q[$past(irq_vec)]);

    // R6: broadcast only follows an end-of-interrupt
    a_r6_bcast_after_eoi: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> $past(eoi));

    // R8: disabled requests leave waiting set untouched
    a_r8_disabled_stable: assert property (@(posedge clk) disable iff (rst)
        (!(hw_en && sw_en) && !ack) |=> $stable(pend_q));

    // R9: error only for a low vector request
    a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(req_valid && req_vec < 8'd16));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en),
    .req_valid(req_valid), .req_vec(req_vec), .ack(ack), .eoi(eoi),
    .irq_avail(irq_avail), .irq_vec(irq_vec), .eoi_bcast(eoi_bcast),
    .req_err(req_err), .pend_q(pend_q), .isr_q(isr_q), .ppr(ppr)
);

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       hw_en, sw_en, req_valid, req_level, tpr_we, ack, eoi;
    logic [7:0] req_vec, tpr_wdata;
    logic       irq_avail, eoi_bcast, req_err;
    logic [7:0] irq_vec, eoi_bcast_vec;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] bcast_q [$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_accept_unit u_irq_accept_unit (
        .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack(ack), .eoi(eoi),
        .irq_avail(irq_avail), .irq_vec(irq_vec), .eoi_bcast(eoi_bcast),
        .eoi_bcast_vec(eoi_bcast_vec), .req_err(req_err)
    );

    // Monitor: every broadcast must match the next expected vector (R6)
    always @(posedge clk) begin
        #2;
        if (!rst && eoi_bcast) begin
            n_tests++;
            if (bcast_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected broadcast actual=%02h expected=none", eoi_bcast_vec);
            end else begin
                logic [7:0] exp_v;
                exp_v = bcast_q.pop_front();
                if (eoi_bcast_vec !== exp_v) begin
                    n_fail++;
                    $display("FAIL R6 broadcast vector actual=%02h expected=%02h", eoi_bcast_vec, exp_v);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        req_valid = 0; tpr_we = 0; ack = 0; eoi = 0;
    endtask

    task automatic send(input logic [7:0] v, input logic lvl);
        req_valid = 1; req_vec = v; req_level = lvl; step();
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we = 1; tpr_wdata = v; step();
    endtask

    task automatic do_ack();  ack = 1; step(); endtask

    task automatic do_eoi(input bit expect_bc, input logic [7:0] v);
        if (expect_bc) bcast_q.push_back(v);
        eoi = 1; step();
    endtask

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp_v);
        end
    endtask

    task automatic chk_irq(input string tag, input logic av, input logic [7:0] v);
        chk(tag, {irq_avail, irq_vec}, {av, av ? v : 8'h00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; hw_en = 0; sw_en = 0; req_valid = 0; req_vec = 0; req_level = 0;
        tpr_we = 0; tpr_wdata = 0; ack = 0; eoi = 0;
        repeat (3) @(posedge clk); #1;
        rst = 0; #1;
        chk("R1 reset outputs", {irq_avail, eoi_bcast, req_err, 6'd0}, 9'd0);
        hw_en = 1; sw_en = 1;

        // R2: highest waiting vector, within and across classes
        send(8'h35, 0); chk_irq("R2 single", 1, 8'h35);
        send(8'h3A, 0); chk_irq("R2 same class msb", 1, 8'h3A);
        send(8'h80, 0); chk_irq("R2 higher word", 1, 8'h80);

        // R10 / R3: task priority gating, strict compare
        wr_tpr(8'h90); chk_irq("R10 tpr blocks", 0, 0);
        wr_tpr(8'h80); chk_irq("R3 equal class blocked", 0, 0);
        wr_tpr(8'h7F); chk_irq("R3 class above tpr", 1, 8'h80);
        wr_tpr(8'h00);

        // R4: ack moves 0x80 into service; in-service class now gates
        do_ack(); chk_irq("R4 ack raises ppr", 0, 0);
        send(8'h91, 1); chk_irq("R3 nested higher class", 1, 8'h91);
        do_ack(); chk_irq("R4 second ack", 0, 0);

        // R5/R6: retire level 0x91 then edge 0x80
        do_eoi(1, 8'h91); chk_irq("R5 first eoi still blocked", 0, 0);
        do_eoi(0, 0); chk("R6 edge no broadcast", {8'd0, eoi_bcast}, 9'd0);
        chk_irq("R5 unwound", 1, 8'h3A);

        // R4: ack without irq_avail ignored
        wr_tpr(8'hF0); do_ack(); wr_tpr(8'h00);
        chk_irq("R4 ignored ack", 1, 8'h3A);

        do_ack(); chk_irq("R3 same class as isr blocked", 0, 0);
        do_eoi(0, 0); chk_irq("R5 after eoi", 1, 8'h35);
        do_ack(); do_eoi(0, 0);
        do_eoi(0, 0); chk_irq("R5 empty eoi no effect", 0, 0);
        chk("R5 empty eoi no broadcast", {8'd0, eoi_bcast}, 9'd0);

        // R7: level request on waiting edge vector is dropped
        send(8'h50, 0); send(8'h50, 1);
        chk_irq("R7 still waiting", 1, 8'h50);
        do_ack(); do_eoi(0, 0);
        chk("R7 dropped level no broadcast", {8'd0, eoi_bcast}, 9'd0);
        send(8'h60, 1); do_ack(); do_eoi(1, 8'h60);
        chk("R7 fresh level broadcast", {8'd0, eoi_bcast}, 9'd1);
        step(); chk("R6 one cycle strobe", {8'd0, eoi_bcast}, 9'd0);

        // R8: enables
        sw_en = 0; send(8'h70, 0); chk_irq("R8 sw disabled", 0, 0);
        sw_en = 1; hw_en = 0; send(8'h71, 0); chk_irq("R8 hw disabled", 0, 0);
        hw_en = 1; step(); chk_irq("R8 not latched", 0, 0);

        // R9: illegal low vectors
        send(8'h0F, 0); chk("R9 error pulse", {8'd0, req_err}, 9'd1);
        chk_irq("R9 dropped", 0, 0);
        send(8'h10, 0); chk("R9 boundary legal", {8'd0, req_err}, 9'd0);
        chk_irq("R9 vector 16 accepted", 1, 8'h10);

        // R3: task priority above in-service class
        do_ack(); wr_tpr(8'h25);
        send(8'h2F, 0); chk_irq("R3 tpr low nibble counts", 0, 0);
        send(8'h30, 0); chk_irq("R3 above tpr", 1, 8'h30);

        repeat (3) step();
        chk("R6 all broadcasts seen", {1'b0, 8'(bcast_q.size())}, 9'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule